// File: doc/BRIEF.md
# MDIO Management Write Master

This block is a host-programmable master for the two-wire PHY management bus. Software sets a clock divider code, a PHY address and a PHY register address. It then writes 16 bits of data to a control register. That write sends one clause-22 write frame on the serial data line, clocked by a management clock derived from the system clock. Software polls an indicator register until the busy flag drops before it starts the next frame. A typical use is bringing up a PHY: write the advertisement register, then write the control register to restart auto-negotiation.

The host side is a plain synchronous register port. A write is accepted in the cycle `reg_wr_en` is high. Reads are combinational from `reg_addr`. There is no back-pressure: a control write that arrives while a frame is in flight is dropped, so software must poll busy first. The serial side is a clock output, a data output and an output enable. The output enable lets a pad tristate the shared data line.

Top module: `mdio_wr_master`

## Requirements
- R1: After reset, every register reads 0, `mdc` is low and `mdio_oe` is low.
- R2: The configuration register (offset 0) holds a 4-bit divider code in bits 3:0, with the upper bits reading 0. While a frame runs, `mdc` is high for code/2+1 system clocks and low for the same count. The full period is therefore 2*(code/2+1) clocks, so code 0xD gives a divide of 14.
- R3: The address register (offset 1) holds the PHY address in bits 12:8 and the register address in bits 4:0. All other bits read 0.
- R4: A write to the control register (offset 2) while busy is 0 launches a frame carrying bits 15:0 of the write. The control register then reads back that data.
- R5: The frame holds 64 bits in this order: 32 ones, 01, 01, the PHY address MSB first, the register address MSB first, 10, and the 16 data bits MSB first. Bit k is the value on `mdio_o` at the k-th rising edge of `mdc`.
- R6: While the output enable stays high, `mdio_o` changes only on the clock edge where `mdc` falls.
- R7: Bit 0 of the indicator register (offset 3) reads 1 from the cycle after a launch, for exactly 64 full `mdc` periods, then reads 0.
- R8: While busy, a control write changes neither the frame in flight nor the control readback. A configuration write while busy does not alter the running `mdc` period.
- R9: Whenever busy is 0, `mdc` is low and `mdio_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Host register write strobe |
| reg_addr | input | 2 | Host register select: 0 config, 1 address, 2 control, 3 indicator |
| reg_wdata | input | 16 | Host write data |
| reg_rdata | output | 16 | Read data of the selected register |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Serial management data out |
| mdio_oe | output | 1 | Output enable for the management data pad |

## Verification
The assertions assume that `reg_wr_en`, `reg_addr` and `reg_wdata` are free of X and change only away from the rising clock edge. They also assume the first launch comes after reset is released. The bench drives every host input at the falling clock edge and samples the outputs one time unit later. It holds `reg_addr` at the indicator register while it watches a frame, and it moves `reg_addr` to another register only for the single cycle of a deliberate mid-frame write.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int HOST_AW = 2;
  localparam logic [HOST_AW-1:0] OFS_CFG  = 2'd0;
  localparam logic [HOST_AW-1:0] OFS_ADDR = 2'd1;
  localparam logic [HOST_AW-1:0] OFS_CTRL = 2'd2;
  localparam logic [HOST_AW-1:0] OFS_IND  = 2'd3;

  localparam int PHY_W   = 5;
  localparam int REGA_W  = 5;
  localparam int MDATA_W = 16;
  localparam int PRE_LEN = 32;
  localparam int FRAME_LEN = PRE_LEN + 2 + 2 + PHY_W + REGA_W + 2 + MDATA_W;
  localparam int CNT_W = $clog2(FRAME_LEN);

  // Clause-22 write frame, first bit on the wire in the MSB.
  function automatic logic [FRAME_LEN-1:0] build_frame(
    input logic [PHY_W-1:0]   phy,
    input logic [REGA_W-1:0]  ra,
    input logic [MDATA_W-1:0] d
  );
    return {{PRE_LEN{1'b1}}, 2'b01, 2'b01, phy, ra, 2'b10, d};
  endfunction
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CODE_W-1:0] code,
  input  logic              active,
  output logic              mdc,
  output logic              fall_stb,
  output logic [CODE_W-1:0] half_len
);
  localparam int HALF_W = CODE_W;

  logic [HALF_W-1:0] half_q;
  logic [HALF_W-1:0] cnt_q;
  logic              mdc_q;
  logic              at_edge;

  assign at_edge  = (cnt_q == half_q - HALF_W'(1));
  assign fall_stb = active && at_edge && mdc_q;
  assign mdc      = mdc_q;
  assign half_len = half_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= HALF_W'(1);
      cnt_q  <= '0;
      mdc_q  <= 1'b0;
    end else if (start) begin
      // divider code is latched once per frame
      half_q <= {1'b0, code[CODE_W-1:1]} + HALF_W'(1);
      cnt_q  <= '0;
      mdc_q  <= 1'b0;
    end else if (active) begin
      if (at_edge) begin
        cnt_q <= '0;
        mdc_q <= ~mdc_q;
      end else begin
        cnt_q <= cnt_q + HALF_W'(1);
      end
    end else begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end
  end
endmodule

// File: rtl/mdio_frame_tx.sv
module mdio_frame_tx
  import mdio_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [FRAME_LEN-1:0] frame,
  input  logic                 shift_stb,
  output logic                 busy,
  output logic                 mdio_o
);
  logic [FRAME_LEN-1:0] sh_q;
  logic [CNT_W-1:0]     left_q;
  logic                 busy_q;

  assign busy   = busy_q;
  assign mdio_o = busy_q & sh_q[FRAME_LEN-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      left_q <= '0;
      busy_q <= 1'b0;
    end else if (start) begin
      sh_q   <= frame;
      left_q <= CNT_W'(FRAME_LEN - 1);
      busy_q <= 1'b1;
    end else if (busy_q && shift_stb) begin
      if (left_q == '0) begin
        busy_q <= 1'b0;
      end else begin
        sh_q   <= {sh_q[FRAME_LEN-2:0], 1'b0};
        left_q <= left_q - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/mdio_host_regs.sv
module mdio_host_regs
  import mdio_pkg::*;
#(
  parameter int CODE_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [HOST_AW-1:0] addr,
  input  logic [MDATA_W-1:0] wdata,
  input  logic               busy,
  output logic [MDATA_W-1:0] rdata,
  output logic [CODE_W-1:0]  div_code,
  output logic [PHY_W-1:0]   phy_sel,
  output logic [REGA_W-1:0]  reg_sel,
  output logic [MDATA_W-1:0] ctrl_data,
  output logic               launch
);
  logic [CODE_W-1:0]  code_q;
  logic [PHY_W-1:0]   phy_q;
  logic [REGA_W-1:0]  ra_q;
  logic [MDATA_W-1:0] data_q;

  assign launch    = wr_en && (addr == OFS_CTRL) && !busy;
  assign div_code  = code_q;
  assign phy_sel   = phy_q;
  assign reg_sel   = ra_q;
  assign ctrl_data = data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      phy_q  <= '0;
      ra_q   <= '0;
      data_q <= '0;
    end else begin
      if (wr_en && addr == OFS_CFG)  code_q <= wdata[CODE_W-1:0];
      if (wr_en && addr == OFS_ADDR) begin
        phy_q <= wdata[8 +: PHY_W];
        ra_q  <= wdata[0 +: REGA_W];
      end
      if (launch) data_q <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      OFS_CFG:  rdata[CODE_W-1:0] = code_q;
      OFS_ADDR: begin
        rdata[8 +: PHY_W]  = phy_q;
        rdata[0 +: REGA_W] = ra_q;
      end
      OFS_CTRL: rdata = data_q;
      default:  rdata[0] = busy;
    endcase
  end
endmodule

// File: rtl/mdio_wr_master.sv
module mdio_wr_master
  import mdio_pkg::*;
#(
  parameter int DIV_CODE_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr_en,
  input  logic [HOST_AW-1:0] reg_addr,
  input  logic [MDATA_W-1:0] reg_wdata,
  output logic [MDATA_W-1:0] reg_rdata,
  output logic               mdc,
  output logic               mdio_o,
  output logic               mdio_oe
);
  logic                  busy;
  logic                  launch;
  logic                  fall_stb;
  logic [DIV_CODE_W-1:0] div_code;
  logic [DIV_CODE_W-1:0] half_len;
  logic [PHY_W-1:0]      phy_sel;
  logic [REGA_W-1:0]     reg_sel;
  logic [MDATA_W-1:0]    ctrl_data;
  logic [FRAME_LEN-1:0]  frame;

  assign frame   = build_frame(phy_sel, reg_sel, reg_wdata);
  assign mdio_oe = busy;

  mdio_host_regs #(.CODE_W(DIV_CODE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
    .wdata(reg_wdata), .busy(busy), .rdata(reg_rdata),
    .div_code(div_code), .phy_sel(phy_sel), .reg_sel(reg_sel),
    .ctrl_data(ctrl_data), .launch(launch)
  );

  mdio_mdc_gen #(.CODE_W(DIV_CODE_W)) u_clk (
    .clk(clk), .rst_n(rst_n), .start(launch), .code(div_code),
    .active(busy), .mdc(mdc), .fall_stb(fall_stb), .half_len(half_len)
  );

  mdio_frame_tx u_tx (
    .clk(clk), .rst_n(rst_n), .start(launch), .frame(frame),
    .shift_stb(fall_stb), .busy(busy), .mdio_o(mdio_o)
  );
endmodule

// File: rtl/mdio_wr_master_chk.sv
module mdio_wr_master_chk
  import mdio_pkg::*;
#(
  parameter int HALF_W = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               mdc,
  input logic               mdio_o,
  input logic               mdio_oe,
  input logic               busy,
  input logic               launch,
  input logic [MDATA_W-1:0] ctrl_data,
  input logic [HALF_W-1:0]  half_len,
  input logic               reg_wr_en,
  input logic [HOST_AW-1:0] reg_addr
);
  logic        mdc_d, busy_d;
  logic [15:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mdc_d  <= 1'b0;
      busy_d <= 1'b0;
      run    <= '0;
    end else begin
      mdc_d  <= mdc;
      busy_d <= busy;
      run    <= ((mdc != mdc_d) || (busy && !busy_d)) ? 16'd1 : run + 16'd1;
    end
  end

  // R9
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe));

  // R7
  launch_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> busy);

  // R8
  busy_hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr_en && reg_addr == OFS_CTRL) |=> $stable(ctrl_data));

  // R6
  mdio_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mdio_oe && $past(mdio_oe) && mdio_o != $past(mdio_o)) |-> (!mdc && $past(mdc)));

  // R2
  half_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && busy_d && mdc != mdc_d) |-> run == 16'(half_len));
endmodule

bind mdio_wr_master mdio_wr_master_chk #(.HALF_W(DIV_CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
  .busy(busy), .launch(launch), .ctrl_data(ctrl_data), .half_len(half_len),
  .reg_wr_en(reg_wr_en), .reg_addr(reg_addr)
);

// File: tb/tb_mdio_wr_master.sv
module tb_mdio_wr_master;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [1:0]  reg_addr = 2'd3;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdio_wr_master dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  // {code[3:0], phy[4:0], reg[4:0], data[15:0], inject}
  localparam int NV = 5;
  localparam logic [30:0] VEC [NV] = '{
    {4'hD, 5'h11, 5'h04, 16'h01E1, 1'b0},
    {4'hD, 5'h11, 5'h00, 16'h1200, 1'b0},
    {4'h0, 5'h1F, 5'h1F, 16'hFFFF, 1'b0},
    {4'h1, 5'h00, 5'h00, 16'h0000, 1'b0},
    {4'h4, 5'h05, 5'h0A, 16'hA55A, 1'b1}
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic host_wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0; reg_addr = 2'd3;
  endtask

  task automatic host_rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
    reg_addr = 2'd3;
  endtask

  task automatic run_vec(input logic [30:0] v);
    logic [3:0]  code; logic [4:0] phy, ra; logic [15:0] data; bit inj;
    logic [63:0] exp_frame, got;
    int half, nbits, busy_cnt, bad_runs, cur_len, n;
    logic prev_mdc;
    logic [15:0] rd;
    {code, phy, ra, data, inj} = v;
    half = code / 2 + 1;
    exp_frame = {32'hFFFF_FFFF, 2'b01, 2'b01, phy, ra, 2'b10, data};
    host_wr(2'd0, {12'h000, code});
    host_wr(2'd1, {3'b000, phy, 3'b000, ra});
    // launch write, captured at the next rising edge
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = 2'd2; reg_wdata = data;
    got = '0; nbits = 0; busy_cnt = 0; bad_runs = 0; cur_len = 0; prev_mdc = 1'b0; n = 0;
    forever begin
      @(negedge clk);
      reg_wr_en = 1'b0; reg_addr = 2'd3;
      #1;
      if (!reg_rdata[0]) break;
      busy_cnt++;
      n++;
      if (!mdio_oe) bad_runs += 1000;
      if (mdc != prev_mdc) begin
        if (cur_len != half) bad_runs++;
        if (mdc) begin got = {got[62:0], mdio_o}; nbits++; end
        cur_len = 1;
      end else cur_len++;
      prev_mdc = mdc;
      if (n > 5000) break;
      // R8: mid-frame writes to control and config
      if (inj && n == 40) begin reg_wr_en = 1'b1; reg_addr = 2'd2; reg_wdata = 16'hDEAD; end
      if (inj && n == 41) begin reg_wr_en = 1'b1; reg_addr = 2'd0; reg_wdata = 16'h0000; end
    end
    check(got == exp_frame && nbits == 64, inj ? "R8 frame" : "R5 frame", got, exp_frame);
    check(busy_cnt == 64 * 2 * half, "R7 busy length", busy_cnt, 64 * 2 * half);
    check(bad_runs == 0, inj ? "R8/R2 mdc half period" : "R2 mdc half period", bad_runs, 0);
    check(!mdc && !mdio_oe, "R9 idle release", {mdc, mdio_oe}, 0);
    host_rd(2'd2, rd);
    check(rd == data, inj ? "R8 ctrl readback" : "R4 ctrl readback", rd, data);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    repeat (3) @(negedge clk);
    #1;
    check(!mdc && !mdio_oe, "R1 outputs", {mdc, mdio_oe}, 0);
    rst_n = 1'b1;
    for (int a = 0; a < 4; a++) begin
      host_rd(2'(a), rd);
      check(rd == 16'h0, "R1 register reset", rd, 0);
    end
    // R3 / R2 field masking
    host_wr(2'd1, 16'hFFFF);
    host_rd(2'd1, rd);
    check(rd == 16'h1F1F, "R3 address fields", rd, 16'h1F1F);
    host_wr(2'd0, 16'hFFFF);
    host_rd(2'd0, rd);
    check(rd == 16'h000F, "R2 divider code field", rd, 16'h000F);
    for (int i = 0; i < NV; i++) run_vec(VEC[i]);
    // largest code
    run_vec({4'hF, 5'h0A, 5'h15, 16'h8001, 1'b0});
    host_rd(2'd3, rd);
    check(rd == 16'h0, "R7 indicator idle", rd, 0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule